// File: doc/BRIEF.md
# Radio Mode Sequencer with Post-Transmit Lockout

This controller sits on the baseband side of a radio and moves it between idle, receive and transmit. When a start request arrives in idle, it writes a mode pattern into the radio's control register through a simple register-write interface. The pattern sets or clears three enable bits: transmit enable, receive enable and narrow bandwidth. Once the write is acknowledged, the controller raises a master cycle strobe. A high strobe means a transmit or receive cycle is running. A falling strobe means the radio enters idle and begins powering down.

When an end-of-cycle request arrives, the strobe drops. The radio still emits residual RF power for a short while after a transmit, so the controller then withholds the register-port grant for a fixed number of clock cycles. No new cycle may begin during that time. The receive path uses the same hold-off by default, and a parameter can remove it.

Any start request that arrives while a cycle or a hold-off is in progress is dropped, and the controller reports it with a one-cycle error pulse.

Top module: `radio_mode_seq`

## Requirements
- R1: After reset the block is idle: `radioStrobe` is 0, `busy` is 0, `wrReq` is 0, `reqError` is 0 and `accessGrant` is 1.
- R2: A receive start in idle raises `wrReq` in the next cycle. In that cycle `wrAddr` equals `CTRL_ADDR` and `wrData` has bit 13 set, bits 14 and 12 clear, and all other bits 0 (0x2000 at the default width).
- R3: A transmit start in idle raises `wrReq` in the next cycle. In that cycle `wrData` has bits 14 and 12 set, bit 13 clear, and all other bits 0 (0x5000).
- R4: `wrReq` stays high, and `radioStrobe` stays low, until `wrAck` is sampled high. `radioStrobe` is high in the cycle after that sample, and `wrReq` is then low.
- R5: `radioStrobe` stays high until `endCycle` is sampled, and is low in the next cycle. An `endCycle` outside an active cycle has no effect.
- R6: After a transmit, `accessGrant` stays 0 and `busy` stays 1 for exactly `HOLD_CYC` cycles after the strobe falls. After that the block is idle with `accessGrant` at 1.
- R7: After a receive, the hold-off lasts `HOLD_CYC` cycles when `RX_HOLD_EN` is 1. When `RX_HOLD_EN` is 0 there is no hold-off, and `accessGrant` is 1 in the cycle the strobe is low.
- R8: A start request sampled while `busy` is 1 is ignored: the mode, the strobe and the hold-off are unchanged. `reqError` is 1 for exactly the following cycle.
- R9: When receive and transmit starts are sampled together in idle, the transmit start wins and no error is flagged.
- R10: `accessGrant` is never 1 while `radioStrobe` or `wrReq` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startRx | input | 1 | Request a receive cycle |
| startTx | input | 1 | Request a transmit cycle |
| endCycle | input | 1 | End the running cycle |
| wrAck | input | 1 | Register write completed |
| wrReq | output | 1 | Register write command |
| wrAddr | output | ADDR_W | Address of the radio control register |
| wrData | output | DATA_W | Enable-bit pattern to write |
| radioStrobe | output | 1 | Master cycle strobe to the radio |
| busy | output | 1 | Cycle or hold-off in progress |
| accessGrant | output | 1 | Serial register port may be used |
| reqError | output | 1 | One-cycle pulse for a dropped start request |

## Verification
On every cycle, the embedded properties check four things: the write is held until it is acknowledged, the strobe rises only after an acknowledge, the grant is never high together with the strobe or a write, and the grant stays low when a transmit strobe falls. They also check that an error pulse follows only a busy cycle. Only the bench scenarios can show the exact register patterns, the exact hold-off length for each mode, and the transmit priority. The same holds for the zero-length receive hold-off in the second build and for dropped starts leaving the running cycle undisturbed.

// File: rtl/radio_seq_pkg.sv
package radio_seq_pkg;

  localparam int TX_EN_BIT = 14;
  localparam int RX_EN_BIT = 13;
  localparam int NB_EN_BIT = 12;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WRITE  = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_HOLD   = 2'd3
  } seqState_t;

  typedef struct packed {
    logic loadRx;
    logic loadTx;
    logic loadHold;
    logic decHold;
  } seqStrobe_t;

endpackage

// File: rtl/radio_seq_datapath.sv
module radio_seq_datapath
  import radio_seq_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int HOLD_CYC   = 8,
  parameter bit RX_HOLD_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  output logic              modeIsTx,
  output logic [DATA_W-1:0] wrData,
  output logic              holdDone,
  output logic              holdNone
);

  localparam int RX_HOLD = RX_HOLD_EN ? HOLD_CYC : 0;
  localparam int CNT_W   = $clog2(HOLD_CYC + 1) < 1 ? 1 : $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] TX_LOAD = CNT_W'(HOLD_CYC > 0 ? HOLD_CYC - 1 : 0);
  localparam logic [CNT_W-1:0] RX_LOAD = CNT_W'(RX_HOLD > 0 ? RX_HOLD - 1 : 0);
  localparam bit TX_NONE = (HOLD_CYC == 0);
  localparam bit RX_NONE = (RX_HOLD == 0);

  logic [CNT_W-1:0] holdCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeIsTx <= 1'b0;
    end else if (strb.loadTx) begin
      modeIsTx <= 1'b1;
    end else if (strb.loadRx) begin
      modeIsTx <= 1'b0;
    end
  end

  always_comb begin
    wrData            = '0;
    wrData[TX_EN_BIT] = modeIsTx;
    wrData[NB_EN_BIT] = modeIsTx;
    wrData[RX_EN_BIT] = !modeIsTx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (strb.loadHold) begin
      holdCnt <= modeIsTx ? TX_LOAD : RX_LOAD;
    end else if (strb.decHold) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  assign holdDone = (holdCnt == '0);
  assign holdNone = modeIsTx ? TX_NONE : RX_NONE;

  AST_DEC_ABOVE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.decHold |-> holdCnt != '0); // R6

endmodule

// File: rtl/radio_seq_control.sv
module radio_seq_control
  import radio_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startRx,
  input  logic       startTx,
  input  logic       endCycle,
  input  logic       wrAck,
  input  logic       modeIsTx,
  input  logic       holdDone,
  input  logic       holdNone,
  output seqStrobe_t strb,
  output logic       wrReq,
  output logic       radioStrobe,
  output logic       busy,
  output logic       accessGrant,
  output logic       reqError
);

  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (startTx) begin
          strb.loadTx = 1'b1;
          stateNext   = ST_WRITE;
        end else if (startRx) begin
          strb.loadRx = 1'b1;
          stateNext   = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (wrAck) stateNext = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (endCycle) begin
          if (holdNone) begin
            stateNext = ST_IDLE;
          end else begin
            strb.loadHold = 1'b1;
            stateNext     = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (holdDone) stateNext = ST_IDLE;
        else          strb.decHold = 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      reqError <= 1'b0;
    end else begin
      state    <= stateNext;
      reqError <= (startRx || startTx) && (state != ST_IDLE);
    end
  end

  assign wrReq       = (state == ST_WRITE);
  assign radioStrobe = (state == ST_ACTIVE);
  assign busy        = (state != ST_IDLE);
  assign accessGrant = (state == ST_IDLE);

  AST_ACK_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    wrReq && !wrAck |=> wrReq); // R4
  AST_STROBE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(radioStrobe) |-> $past(wrAck)); // R4
  AST_STROBE_NO_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    radioStrobe |-> !accessGrant); // R10
  AST_WRITE_NO_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |-> !accessGrant); // R10
  AST_TX_FALL_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(radioStrobe) && modeIsTx |-> !accessGrant); // R6
  AST_ERR_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    reqError |-> $past(busy)); // R8

endmodule

// File: rtl/radio_mode_seq.sv
module radio_mode_seq
  import radio_seq_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 16,
  parameter int CTRL_ADDR  = 2,
  parameter int HOLD_CYC   = 8,
  parameter bit RX_HOLD_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startRx,
  input  logic              startTx,
  input  logic              endCycle,
  input  logic              wrAck,
  output logic              wrReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              radioStrobe,
  output logic              busy,
  output logic              accessGrant,
  output logic              reqError
);

  seqStrobe_t strb;
  logic       modeIsTx;
  logic       holdDone;
  logic       holdNone;

  assign wrAddr = ADDR_W'(CTRL_ADDR);

  radio_seq_control i_control (
    .clk         (clk),
    .rstN        (rstN),
    .startRx     (startRx),
    .startTx     (startTx),
    .endCycle    (endCycle),
    .wrAck       (wrAck),
    .modeIsTx    (modeIsTx),
    .holdDone    (holdDone),
    .holdNone    (holdNone),
    .strb        (strb),
    .wrReq       (wrReq),
    .radioStrobe (radioStrobe),
    .busy        (busy),
    .accessGrant (accessGrant),
    .reqError    (reqError)
  );

  radio_seq_datapath #(
    .DATA_W     (DATA_W),
    .HOLD_CYC   (HOLD_CYC),
    .RX_HOLD_EN (RX_HOLD_EN)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .modeIsTx (modeIsTx),
    .wrData   (wrData),
    .holdDone (holdDone),
    .holdNone (holdNone)
  );

endmodule

// File: tb/test_radio_mode_seq.sv
module test_radio_mode_seq;

  localparam int HOLD = 6;
  localparam int CADDR = 2;
  localparam logic [15:0] PAT_RX = 16'h2000;
  localparam logic [15:0] PAT_TX = 16'h5000;

  typedef struct packed {
    logic       tx;
    logic [3:0] ackDelay;
    logic [3:0] activeLen;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{tx: 1'b1, ackDelay: 4'd0, activeLen: 4'd3},
    '{tx: 1'b0, ackDelay: 4'd2, activeLen: 4'd1},
    '{tx: 1'b1, ackDelay: 4'd3, activeLen: 4'd5},
    '{tx: 1'b0, ackDelay: 4'd0, activeLen: 4'd2}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startRx = 1'b0, startTx = 1'b0, endCycle = 1'b0, wrAck = 1'b0;
  logic wrReq, radioStrobe, busy, accessGrant, reqError;
  logic [3:0] wrAddr;
  logic [15:0] wrData;
  logic wrReq2, radioStrobe2, busy2, accessGrant2, reqError2;
  logic [3:0] wrAddr2;
  logic [15:0] wrData2;

  int nRun = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  radio_mode_seq #(.HOLD_CYC(HOLD), .CTRL_ADDR(CADDR), .RX_HOLD_EN(1'b1)) i_radio_mode_seq (
    .clk(clk), .rstN(rstN), .startRx(startRx), .startTx(startTx), .endCycle(endCycle),
    .wrAck(wrAck), .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData),
    .radioStrobe(radioStrobe), .busy(busy), .accessGrant(accessGrant), .reqError(reqError));

  radio_mode_seq #(.HOLD_CYC(HOLD), .CTRL_ADDR(CADDR), .RX_HOLD_EN(1'b0)) i_radio_mode_seq_noRxHold (
    .clk(clk), .rstN(rstN), .startRx(startRx), .startTx(startTx), .endCycle(endCycle),
    .wrAck(wrAck), .wrReq(wrReq2), .wrAddr(wrAddr2), .wrData(wrData2),
    .radioStrobe(radioStrobe2), .busy(busy2), .accessGrant(accessGrant2), .reqError(reqError2));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  task automatic runCycle(input logic tx, input int ackDelay, input int activeLen, input int expHold);
    int n;
    startTx = tx;
    startRx = !tx;
    step();
    startTx = 1'b0;
    startRx = 1'b0;
    chk(wrReq, 1, tx ? "R3 wrReq" : "R2 wrReq");
    chk(wrData, tx ? PAT_TX : PAT_RX, tx ? "R3 pattern" : "R2 pattern");
    chk(wrAddr, CADDR, "R2 address");
    chk(radioStrobe, 0, "R4 strobe before ack");
    for (int i = 0; i < ackDelay; i++) begin
      step();
      chk({wrReq, radioStrobe}, 2'b10, "R4 waiting for ack");
    end
    wrAck = 1'b1;
    step();
    wrAck = 1'b0;
    chk({wrReq, radioStrobe, accessGrant}, 3'b010, "R4 strobe after ack");
    for (int i = 0; i < activeLen; i++) begin
      step();
      chk(radioStrobe, 1, "R5 strobe held");
    end
    endCycle = 1'b1;
    step();
    endCycle = 1'b0;
    chk(radioStrobe, 0, "R5 strobe falls");
    n = 0;
    while (!accessGrant && n < 40) begin
      chk(busy, 1, tx ? "R6 busy in hold" : "R7 busy in hold");
      n++;
      step();
    end
    chk(n, expHold, tx ? "R6 hold length" : "R7 hold length");
    chk(busy, 0, "R6 idle after hold");
  endtask

  initial begin
    repeat (3) step();
    chk({radioStrobe, busy, wrReq, reqError, accessGrant}, 5'b00001, "R1 reset state");
    chk({radioStrobe2, busy2, wrReq2, reqError2, accessGrant2}, 5'b00001, "R1 reset state 2");
    rstN = 1'b1;
    step();
    chk({radioStrobe, busy, accessGrant}, 3'b001, "R1 after release");

    for (int v = 0; v < 4; v++) begin
      runCycle(VECS[v].tx, int'(VECS[v].ackDelay), int'(VECS[v].activeLen), HOLD);
      step();
    end

    // R7: no receive hold-off in the second build
    startRx = 1'b1;
    step();
    startRx = 1'b0;
    wrAck = 1'b1;
    step();
    wrAck = 1'b0;
    chk(radioStrobe2, 1, "R7 strobe up");
    endCycle = 1'b1;
    step();
    endCycle = 1'b0;
    chk({radioStrobe2, busy2, accessGrant2}, 3'b001, "R7 no rx hold");
    chk(accessGrant, 0, "R7 rx hold kept when enabled");
    repeat (HOLD + 1) step();

    // R5: endCycle in idle
    endCycle = 1'b1;
    step();
    endCycle = 1'b0;
    step();
    chk({radioStrobe, busy, accessGrant}, 3'b001, "R5 stray endCycle ignored");

    // R8: start while active and while holding
    startTx = 1'b1;
    step();
    startTx = 1'b0;
    wrAck = 1'b1;
    step();
    wrAck = 1'b0;
    startRx = 1'b1;
    step();
    startRx = 1'b0;
    chk(reqError, 1, "R8 error pulse active");
    chk({radioStrobe, wrReq}, 2'b10, "R8 cycle undisturbed");
    chk(wrData, PAT_TX, "R8 mode kept");
    step();
    chk(reqError, 0, "R8 pulse one cycle");
    endCycle = 1'b1;
    step();
    endCycle = 1'b0;
    step();
    startTx = 1'b1;
    step();
    startTx = 1'b0;
    chk({reqError, accessGrant, wrReq}, 3'b100, "R8 error in hold");
    repeat (HOLD - 2) step();
    chk({busy, accessGrant, wrReq}, 3'b010, "R8 hold length unchanged");
    step();
    chk({busy, wrReq}, 2'b00, "R8 dropped start not replayed");

    // R9: both starts together
    startTx = 1'b1;
    startRx = 1'b1;
    step();
    startTx = 1'b0;
    startRx = 1'b0;
    chk(wrData, PAT_TX, "R9 tx priority");
    chk(reqError, 0, "R9 no error");
    wrAck = 1'b1;
    step();
    wrAck = 1'b0;
    endCycle = 1'b1;
    step();
    endCycle = 1'b0;
    repeat (HOLD) step();
    chk(accessGrant, 1, "R6 grant back");

    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

endmodule